// File: doc/BRIEF.md
# DDR3 Power-Up and Mode-Register Sequencer

This block takes a DDR3 device from power-up to the point where it can be calibrated. After the synchronous reset is released it steps through a fixed program. First it lets the device out of reset with termination enabled. Next it raises clock enable. It then loads the four mode registers, starting with register 2, then 3, then 1 and finally 0. The last command is a long ZQ calibration, after which a completion flag goes high and stays high. Every hold and gap length is a parameter. The defaults are 50000 cycles for the reset release, 10000 cycles for clock enable, 200 cycles after mode register 0 and 200 cycles after ZQ.

Mode registers 0 and 1 are assembled at elaboration from small parameter codes: CAS latency, write recovery, output drive strength and nominal termination. The code bits are scattered into the non-contiguous address positions the device expects. The assembled register-1 word is also driven on a dedicated output, so that a later write-leveling stage can modify it and write it back. Command strobes are active-high here: a 1 means the corresponding command line is asserted.

Top module: `ddr3_bringup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `ddr_reset_n`, `ddr_cke`, `ddr_odt`, all four strobes and `init_done` low, with `cmd_addr` and `cmd_bank` zero.
- R2: Starting in the first cycle after `rst` falls, `ddr_reset_n` and `ddr_odt` are high and `ddr_cke` is low for exactly T_RELEASE cycles, with no command issued.
- R3: After the release phase, `ddr_cke` rises and stays high for T_CKE idle cycles. From then on `ddr_reset_n`, `ddr_odt` and `ddr_cke` all stay high.
- R4: Four mode-register writes follow, each lasting one cycle with `cmd_cs`, `cmd_ras`, `cmd_cas` and `cmd_we` all high. They go to bank 2, 3, 1 and 0 in that order. The bank-2 write carries MR2_WORD and the bank-3 write carries MR3_WORD.
- R5: Each of the bank-2, bank-3 and bank-1 writes is followed by T_MR_GAP idle cycles, and the bank-0 write by T_MR0 idle cycles. In an idle cycle all strobes are low and address and bank are zero.
- R6: The bank-0 word has CAS code bit 0 at A2, CAS code bits 3:1 at A6:A4, A8 (DLL reset) set, the write-recovery code at A11:A9, and every other bit zero.
- R7: Write recovery is taken as max(WR_CYCLES, 5), rounded up to the next supported value. The codes are 5→1, 6→2, 7→3, 8→4, 10→5, 12→6, 14→7 and 16→0. Any value above 14 uses code 0.
- R8: The bank-1 word has drive code bit 0 at A1, drive code bit 1 at A5, and termination code bits 0, 1 and 2 at A2, A6 and A9, with every other bit zero. `mr1_value` always equals this word.
- R9: After the bank-0 gap, one ZQ calibration cycle follows. In it only `cmd_cs` and `cmd_we` are high, the address is 0x0400 and the bank is 0. It is followed by T_ZQ idle cycles.
- R10: `init_done` rises in the cycle after the last ZQ idle cycle and then stays high, with no further commands and all three levels high.
- R11: Raising `rst` partway through the program returns every output to the R1 state. Releasing it restarts the program from the R2 phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ddr_reset_n | output | 1 | Device reset level (high = released) |
| ddr_cke | output | 1 | Clock enable level |
| ddr_odt | output | 1 | On-die termination level |
| cmd_cs | output | 1 | Chip select strobe, active high |
| cmd_ras | output | 1 | Row strobe, active high |
| cmd_cas | output | 1 | Column strobe, active high |
| cmd_we | output | 1 | Write-enable strobe, active high |
| cmd_addr | output | ADDR_W | Command address / mode word |
| cmd_bank | output | BANK_W | Command bank address |
| mr1_value | output | ADDR_W | Assembled mode register 1 word |
| init_done | output | 1 | Program complete, sticky until reset |

## Verification
Every output is decoded from registered state, so a change in `rst` shows up at the ports one clock edge later. The first program cycle appears right after the first edge at which `rst` is low. After that, each phase lasts exactly its configured number of cycles. The bench keeps a cycle-indexed list of expected port values, built from the parameters. It samples on the falling edge, compares entry k against the k-th cycle after release, and compares the settled final state once the list is used up. Two instances with different timings and codes run side by side, one of them with zero gaps so that mode-register writes come back to back. The checks cover the register-0 and register-1 bit scattering, the write-recovery floor, and a reset that interrupts the program partway through.

// File: rtl/ddr3_bringup_pkg.sv
package ddr3_bringup_pkg;

    // Program steps, in execution order.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RELEASE,
        ST_CKE,
        ST_MR2,
        ST_MR3,
        ST_MR1,
        ST_MR0,
        ST_ZQ,
        ST_DONE
    } step_e;

    // Pin levels held between commands.
    typedef struct packed {
        logic rst_n;
        logic cke;
        logic odt;
    } pin_lvl_t;

    // Active-high command strobes.
    typedef struct packed {
        logic cs;
        logic ras;
        logic cas;
        logic we;
    } strobe_t;

    localparam int unsigned WR_FLOOR    = 5;
    localparam int unsigned ZQ_ADDR_BIT = 10;
    localparam int unsigned BANK_OF_MR0 = 0;
    localparam int unsigned BANK_OF_MR1 = 1;
    localparam int unsigned BANK_OF_MR2 = 2;
    localparam int unsigned BANK_OF_MR3 = 3;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Write-recovery cycles to the 3-bit mode field, floored and rounded up.
    function automatic logic [2:0] wr_code(input int unsigned cyc);
        int unsigned eff;
        eff = max_u(cyc, WR_FLOOR);
        if (eff <= 8)       return 3'(eff - 4);
        else if (eff <= 10) return 3'd5;
        else if (eff <= 12) return 3'd6;
        else if (eff <= 14) return 3'd7;
        else                return 3'd0;
    endfunction

    function automatic logic is_mode_write(input step_e s);
        return (s == ST_MR2) || (s == ST_MR3) || (s == ST_MR1) || (s == ST_MR0);
    endfunction

endpackage

// File: rtl/ddr3_mr_encode.sv
module ddr3_mr_encode #(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned CL_CODE   = 2,
    parameter int unsigned WR_CYCLES = 6,
    parameter int unsigned RON_CODE  = 0,
    parameter int unsigned RTT_CODE  = 1
) (
    output logic [ADDR_W-1:0] mr0_word,
    output logic [ADDR_W-1:0] mr1_word
);
    import ddr3_bringup_pkg::*;

    localparam logic [3:0] CL_BITS  = 4'(CL_CODE);
    localparam logic [2:0] WR_BITS  = wr_code(WR_CYCLES);
    localparam logic [1:0] RON_BITS = 2'(RON_CODE);
    localparam logic [2:0] RTT_BITS = 3'(RTT_CODE);

    always_comb begin
        mr0_word        = '0;
        mr0_word[2]     = CL_BITS[0];
        mr0_word[6:4]   = CL_BITS[3:1];
        mr0_word[8]     = 1'b1;
        mr0_word[11:9]  = WR_BITS;
    end

    always_comb begin
        mr1_word    = '0;
        mr1_word[1] = RON_BITS[0];
        mr1_word[5] = RON_BITS[1];
        mr1_word[2] = RTT_BITS[0];
        mr1_word[6] = RTT_BITS[1];
        mr1_word[9] = RTT_BITS[2];
    end

endmodule

// File: rtl/ddr3_wait_timer.sv
module ddr3_wait_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr3_step_ctrl.sv
module ddr3_step_ctrl #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned T_RELEASE = 50000,
    parameter int unsigned T_CKE     = 10000,
    parameter int unsigned T_MR_GAP  = 0,
    parameter int unsigned T_MR0     = 200,
    parameter int unsigned T_ZQ      = 200
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    expired,
    output logic                    load,
    output logic [CNT_W-1:0]        load_val,
    output ddr3_bringup_pkg::step_e step,
    output logic                    issue
);
    import ddr3_bringup_pkg::*;

    step_e step_q;
    step_e step_nxt;
    logic  issue_q;
    logic  advance;

    // Cycles a step occupies, command cycle included.
    function automatic int unsigned dur_of(input step_e s);
        case (s)
            ST_RELEASE: return max_u(T_RELEASE, 1);
            ST_CKE:     return max_u(T_CKE, 1);
            ST_MR2,
            ST_MR3,
            ST_MR1:     return 1 + T_MR_GAP;
            ST_MR0:     return 1 + T_MR0;
            ST_ZQ:      return 1 + T_ZQ;
            default:    return 1;
        endcase
    endfunction

    always_comb begin
        case (step_q)
            ST_IDLE:    step_nxt = ST_RELEASE;
            ST_RELEASE: step_nxt = ST_CKE;
            ST_CKE:     step_nxt = ST_MR2;
            ST_MR2:     step_nxt = ST_MR3;
            ST_MR3:     step_nxt = ST_MR1;
            ST_MR1:     step_nxt = ST_MR0;
            ST_MR0:     step_nxt = ST_ZQ;
            ST_ZQ:      step_nxt = ST_DONE;
            default:    step_nxt = ST_DONE;
        endcase
    end

    assign advance  = (step_q == ST_IDLE) || ((step_q != ST_DONE) && expired);
    assign load     = advance;
    assign load_val = CNT_W'(dur_of(step_nxt) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q  <= ST_IDLE;
            issue_q <= 1'b0;
        end else begin
            issue_q <= advance;
            if (advance)
                step_q <= step_nxt;
        end
    end

    assign step  = step_q;
    assign issue = issue_q;

endmodule

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode #(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned BANK_W   = 3,
    parameter int unsigned MR2_WORD = 32'h0018,
    parameter int unsigned MR3_WORD = 32'h0000
) (
    input  ddr3_bringup_pkg::step_e    step,
    input  logic                       issue,
    input  logic [ADDR_W-1:0]          mr0_word,
    input  logic [ADDR_W-1:0]          mr1_word,
    output ddr3_bringup_pkg::pin_lvl_t lvl,
    output ddr3_bringup_pkg::strobe_t  strb,
    output logic [ADDR_W-1:0]          addr,
    output logic [BANK_W-1:0]          bank,
    output logic                       done
);
    import ddr3_bringup_pkg::*;

    localparam logic [ADDR_W-1:0] ZQ_ADDR = ADDR_W'(1) << ZQ_ADDR_BIT;

    always_comb begin
        case (step)
            ST_IDLE:    lvl = '{rst_n: 1'b0, cke: 1'b0, odt: 1'b0};
            ST_RELEASE: lvl = '{rst_n: 1'b1, cke: 1'b0, odt: 1'b1};
            default:    lvl = '{rst_n: 1'b1, cke: 1'b1, odt: 1'b1};
        endcase
    end

    always_comb begin
        strb = '0;
        addr = '0;
        bank = '0;
        if (issue) begin
            if (is_mode_write(step))
                strb = '{cs: 1'b1, ras: 1'b1, cas: 1'b1, we: 1'b1};
            case (step)
                ST_MR2: begin
                    addr = ADDR_W'(MR2_WORD);
                    bank = BANK_W'(BANK_OF_MR2);
                end
                ST_MR3: begin
                    addr = ADDR_W'(MR3_WORD);
                    bank = BANK_W'(BANK_OF_MR3);
                end
                ST_MR1: begin
                    addr = mr1_word;
                    bank = BANK_W'(BANK_OF_MR1);
                end
                ST_MR0: begin
                    addr = mr0_word;
                    bank = BANK_W'(BANK_OF_MR0);
                end
                ST_ZQ: begin
                    strb = '{cs: 1'b1, ras: 1'b0, cas: 1'b0, we: 1'b1};
                    addr = ZQ_ADDR;
                end
                default: ;
            endcase
        end
    end

    assign done = (step == ST_DONE);

endmodule

// File: rtl/ddr3_bringup_seq.sv
module ddr3_bringup_seq #(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned BANK_W    = 3,
    parameter int unsigned T_RELEASE = 50000,
    parameter int unsigned T_CKE     = 10000,
    parameter int unsigned T_MR_GAP  = 0,
    parameter int unsigned T_MR0     = 200,
    parameter int unsigned T_ZQ      = 200,
    parameter int unsigned CL_CODE   = 2,
    parameter int unsigned WR_CYCLES = 6,
    parameter int unsigned RON_CODE  = 0,
    parameter int unsigned RTT_CODE  = 1,
    parameter int unsigned MR2_WORD  = 32'h0018,
    parameter int unsigned MR3_WORD  = 32'h0000
) (
    input  logic              clk,
    input  logic              rst,
    output logic              ddr_reset_n,
    output logic              ddr_cke,
    output logic              ddr_odt,
    output logic              cmd_cs,
    output logic              cmd_ras,
    output logic              cmd_cas,
    output logic              cmd_we,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] mr1_value,
    output logic              init_done
);
    import ddr3_bringup_pkg::*;

    localparam int unsigned MAX_DUR = max_u(max_u(max_u(T_RELEASE, T_CKE), max_u(1 + T_MR_GAP, 1 + T_MR0)),
                                            max_u(1 + T_ZQ, 1));
    localparam int unsigned CNT_W   = $clog2(MAX_DUR + 1);

    logic [ADDR_W-1:0] mr0_w;
    logic [ADDR_W-1:0] mr1_w;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_expired;
    step_e             step;
    logic              issue;
    pin_lvl_t          lvl;
    strobe_t           strb;

    ddr3_mr_encode #(
        .ADDR_W    (ADDR_W),
        .CL_CODE   (CL_CODE),
        .WR_CYCLES (WR_CYCLES),
        .RON_CODE  (RON_CODE),
        .RTT_CODE  (RTT_CODE)
    ) u_mr_encode (
        .mr0_word (mr0_w),
        .mr1_word (mr1_w)
    );

    ddr3_wait_timer #(
        .CNT_W (CNT_W)
    ) u_wait_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ddr3_step_ctrl #(
        .CNT_W     (CNT_W),
        .T_RELEASE (T_RELEASE),
        .T_CKE     (T_CKE),
        .T_MR_GAP  (T_MR_GAP),
        .T_MR0     (T_MR0),
        .T_ZQ      (T_ZQ)
    ) u_step_ctrl (
        .clk      (clk),
        .rst      (rst),
        .expired  (tmr_expired),
        .load     (tmr_load),
        .load_val (tmr_val),
        .step     (step),
        .issue    (issue)
    );

    ddr3_cmd_decode #(
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W),
        .MR2_WORD (MR2_WORD),
        .MR3_WORD (MR3_WORD)
    ) u_cmd_decode (
        .step     (step),
        .issue    (issue),
        .mr0_word (mr0_w),
        .mr1_word (mr1_w),
        .lvl      (lvl),
        .strb     (strb),
        .addr     (cmd_addr),
        .bank     (cmd_bank),
        .done     (init_done)
    );

    assign ddr_reset_n = lvl.rst_n;
    assign ddr_cke     = lvl.cke;
    assign ddr_odt     = lvl.odt;
    assign cmd_cs      = strb.cs;
    assign cmd_ras     = strb.ras;
    assign cmd_cas     = strb.cas;
    assign cmd_we      = strb.we;
    assign mr1_value   = mr1_w;

endmodule

// File: rtl/ddr3_bringup_seq_chk.sv
module ddr3_bringup_seq_chk #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned BANK_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              ddr_reset_n,
    input logic              ddr_cke,
    input logic              ddr_odt,
    input logic              cmd_cs,
    input logic              cmd_ras,
    input logic              cmd_cas,
    input logic              cmd_we,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic [BANK_W-1:0] cmd_bank,
    input logic [ADDR_W-1:0] mr1_value,
    input logic              init_done
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!ddr_reset_n && !ddr_cke && !ddr_odt && !cmd_cs && !init_done));

    a_r3_cke_needs_levels: assert property (@(posedge clk) disable iff (rst)
        ddr_cke |-> (ddr_reset_n && ddr_odt));

    a_r3_cke_after_release: assert property (@(posedge clk) disable iff (rst)
        $rose(ddr_cke) |-> $past(ddr_reset_n));

    a_r4_mode_write_strobes: assert property (@(posedge clk) disable iff (rst)
        cmd_ras |-> (cmd_cs && cmd_cas && cmd_we));

    a_r5_idle_is_clean: assert property (@(posedge clk) disable iff (rst)
        !cmd_cs |-> (!cmd_ras && !cmd_cas && !cmd_we && cmd_addr == '0 && cmd_bank == '0));

    a_r8_mr1_on_bus: assert property (@(posedge clk) disable iff (rst)
        (cmd_ras && cmd_bank == BANK_W'(1)) |-> (cmd_addr == mr1_value));

    a_r9_zq_shape: assert property (@(posedge clk) disable iff (rst)
        (cmd_cs && !cmd_ras) |-> (cmd_we && !cmd_cas && cmd_addr == ADDR_W'(1024) && cmd_bank == '0));

    a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (!cmd_cs && ddr_cke && ddr_reset_n && ddr_odt));

endmodule

bind ddr3_bringup_seq ddr3_bringup_seq_chk #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ddr_reset_n (ddr_reset_n),
    .ddr_cke     (ddr_cke),
    .ddr_odt     (ddr_odt),
    .cmd_cs      (cmd_cs),
    .cmd_ras     (cmd_ras),
    .cmd_cas     (cmd_cas),
    .cmd_we      (cmd_we),
    .cmd_addr    (cmd_addr),
    .cmd_bank    (cmd_bank),
    .mr1_value   (mr1_value),
    .init_done   (init_done)
);

// File: tb/ddr3_bringup_seq_bench.sv
`timescale 1ns/1ps
module ddr3_bringup_seq_bench;

    typedef logic [24:0] ev_t;   // {done, rst_n, cke, odt, cs, ras, cas, we, bank[2:0], addr[13:0]}

    // Instance A: zero gaps, write recovery below the floor.
    localparam int unsigned A_TREL = 40, A_TCKE = 20, A_GAP = 0, A_TMR0 = 12, A_TZQ = 9;
    localparam int unsigned A_CL = 11, A_WR = 3, A_RON = 2, A_RTT = 5, A_MR2 = 'h0018, A_MR3 = 'h0004;
    // Instance B: nonzero gaps, write recovery that rounds up.
    localparam int unsigned B_TREL = 25, B_TCKE = 7, B_GAP = 2, B_TMR0 = 5, B_TZQ = 6;
    localparam int unsigned B_CL = 4, B_WR = 11, B_RON = 1, B_RTT = 2, B_MR2 = 'h0208, B_MR3 = 'h0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        a_rn, a_cke, a_odt, a_cs, a_ras, a_cas, a_we, a_done;
    logic [13:0] a_addr, a_mr1;
    logic [2:0]  a_bank;
    logic        b_rn, b_cke, b_odt, b_cs, b_ras, b_cas, b_we, b_done;
    logic [13:0] b_addr, b_mr1;
    logic [2:0]  b_bank;

    ddr3_bringup_seq #(
        .T_RELEASE(A_TREL), .T_CKE(A_TCKE), .T_MR_GAP(A_GAP), .T_MR0(A_TMR0), .T_ZQ(A_TZQ),
        .CL_CODE(A_CL), .WR_CYCLES(A_WR), .RON_CODE(A_RON), .RTT_CODE(A_RTT),
        .MR2_WORD(A_MR2), .MR3_WORD(A_MR3)
    ) u_ddr3_bringup_seq (
        .clk(clk), .rst(rst), .ddr_reset_n(a_rn), .ddr_cke(a_cke), .ddr_odt(a_odt),
        .cmd_cs(a_cs), .cmd_ras(a_ras), .cmd_cas(a_cas), .cmd_we(a_we),
        .cmd_addr(a_addr), .cmd_bank(a_bank), .mr1_value(a_mr1), .init_done(a_done)
    );

    ddr3_bringup_seq #(
        .T_RELEASE(B_TREL), .T_CKE(B_TCKE), .T_MR_GAP(B_GAP), .T_MR0(B_TMR0), .T_ZQ(B_TZQ),
        .CL_CODE(B_CL), .WR_CYCLES(B_WR), .RON_CODE(B_RON), .RTT_CODE(B_RTT),
        .MR2_WORD(B_MR2), .MR3_WORD(B_MR3)
    ) u_ddr3_bringup_seq_b (
        .clk(clk), .rst(rst), .ddr_reset_n(b_rn), .ddr_cke(b_cke), .ddr_odt(b_odt),
        .cmd_cs(b_cs), .cmd_ras(b_ras), .cmd_cas(b_cas), .cmd_we(b_we),
        .cmd_addr(b_addr), .cmd_bank(b_bank), .mr1_value(b_mr1), .init_done(b_done)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    bit restarted = 1'b0;

    ev_t   qa[$];
    ev_t   qb[$];
    string ta[$];
    string tb_tags[$];

    function automatic ev_t mk(input bit dn, input bit rn, input bit ck, input bit od,
                               input bit cs, input bit ras, input bit cas, input bit we,
                               input int unsigned bk, input int unsigned ad);
        return {dn, rn, ck, od, cs, ras, cas, we, bk[2:0], ad[13:0]};
    endfunction

    // R7: floor 5, round up to 5,6,7,8,10,12,14,16 with codes 1..7,0
    function automatic int unsigned exp_wr(input int unsigned cyc);
        int unsigned w;
        w = (cyc < 5) ? 5 : cyc;
        case (w)
            5: return 1;
            6: return 2;
            7: return 3;
            8: return 4;
            9, 10: return 5;
            11, 12: return 6;
            13, 14: return 7;
            default: return 0;
        endcase
    endfunction

    // R6
    function automatic int unsigned exp_mr0(input int unsigned cl, input int unsigned wr);
        int unsigned v;
        v = 0;
        if (cl[0]) v += 4;
        v += ((cl >> 1) & 7) * 16;
        v += 256;
        v += exp_wr(wr) * 512;
        return v;
    endfunction

    // R8
    function automatic int unsigned exp_mr1(input int unsigned ron, input int unsigned rtt);
        int unsigned v;
        v = 0;
        if (ron[0]) v += 2;
        if (ron[1]) v += 32;
        if (rtt[0]) v += 4;
        if (rtt[1]) v += 64;
        if (rtt[2]) v += 512;
        return v;
    endfunction

    task automatic put(input int inst, input ev_t v, input string t);
        if (inst == 0) begin qa.push_back(v); ta.push_back(t); end
        else           begin qb.push_back(v); tb_tags.push_back(t); end
    endtask

    task automatic build(input int inst, input int unsigned trel, input int unsigned tcke,
                         input int unsigned gap, input int unsigned tmr0, input int unsigned tzq,
                         input int unsigned mr2, input int unsigned mr3,
                         input int unsigned mr1, input int unsigned mr0);
        ev_t idle;
        idle = mk(0, 1, 1, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < int'(trel); i++) put(inst, mk(0, 1, 0, 1, 0, 0, 0, 0, 0, 0), "R2");
        for (int i = 0; i < int'(tcke); i++) put(inst, idle, "R3");
        put(inst, mk(0, 1, 1, 1, 1, 1, 1, 1, 2, mr2), "R4");
        for (int i = 0; i < int'(gap); i++) put(inst, idle, "R5");
        put(inst, mk(0, 1, 1, 1, 1, 1, 1, 1, 3, mr3), "R4");
        for (int i = 0; i < int'(gap); i++) put(inst, idle, "R5");
        put(inst, mk(0, 1, 1, 1, 1, 1, 1, 1, 1, mr1), "R8");
        for (int i = 0; i < int'(gap); i++) put(inst, idle, "R5");
        put(inst, mk(0, 1, 1, 1, 1, 1, 1, 1, 0, mr0), "R6 R7");
        for (int i = 0; i < int'(tmr0); i++) put(inst, idle, "R5");
        put(inst, mk(0, 1, 1, 1, 1, 0, 0, 1, 0, 'h400), "R9");
        for (int i = 0; i < int'(tzq); i++) put(inst, idle, "R9");
    endtask

    function automatic ev_t act_a();
        return {a_done, a_rn, a_cke, a_odt, a_cs, a_ras, a_cas, a_we, a_bank, a_addr};
    endfunction
    function automatic ev_t act_b();
        return {b_done, b_rn, b_cke, b_odt, b_cs, b_ras, b_cas, b_we, b_bank, b_addr};
    endfunction

    task automatic check_vec(input string tag, input string who, input ev_t act, input ev_t exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, who, act, exp, $time);
        end
    endtask

    task automatic compare_at(input int idx);
        ev_t   fin;
        ev_t   ea;
        ev_t   eb;
        string tgA;
        string tgB;
        fin = mk(1, 1, 1, 1, 0, 0, 0, 0, 0, 0);
        if (idx < qa.size()) begin ea = qa[idx]; tgA = ta[idx]; end
        else begin ea = fin; tgA = "R10"; end
        if (idx < qb.size()) begin eb = qb[idx]; tgB = tb_tags[idx]; end
        else begin eb = fin; tgB = "R10"; end
        if (restarted && idx < 3) begin tgA = "R11"; tgB = "R11"; end
        check_vec(tgA, "inst A", act_a(), ea);
        check_vec(tgB, "inst B", act_b(), eb);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (3000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin : stim
        build(0, A_TREL, A_TCKE, A_GAP, A_TMR0, A_TZQ, A_MR2, A_MR3,
              exp_mr1(A_RON, A_RTT), exp_mr0(A_CL, A_WR));
        build(1, B_TREL, B_TCKE, B_GAP, B_TMR0, B_TZQ, B_MR2, B_MR3,
              exp_mr1(B_RON, B_RTT), exp_mr0(B_CL, B_WR));

        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            check_vec("R1", "inst A", act_a(), '0);
            check_vec("R1", "inst B", act_b(), '0);
        end

        // R8: exported word
        checks++;
        if (a_mr1 !== 14'(exp_mr1(A_RON, A_RTT))) begin
            failures++;
            $display("FAIL R8 inst A mr1_value: actual=%h expected=%h", a_mr1, exp_mr1(A_RON, A_RTT));
        end
        checks++;
        if (b_mr1 !== 14'(exp_mr1(B_RON, B_RTT))) begin
            failures++;
            $display("FAIL R8 inst B mr1_value: actual=%h expected=%h", b_mr1, exp_mr1(B_RON, B_RTT));
        end

        // First run, interrupted partway (R11)
        rst = 1'b0;
        for (int k = 0; k < 33; k++) begin
            @(negedge clk);
            compare_at(k);
        end
        rst = 1'b1;
        repeat (2) begin
            @(negedge clk);
            check_vec("R11", "inst A", act_a(), '0);
            check_vec("R11", "inst B", act_b(), '0);
        end

        // Full run after restart, into the settled done state (R10)
        rst = 1'b0;
        restarted = 1'b1;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            compare_at(k);
        end
        finish_run();
    end

endmodule